// File: doc/BRIEF.md
# Outstanding Transaction Tracking Table

Each agent on a split-transaction bus keeps one copy of this table to follow every transaction that has been granted the bus and not yet answered. When a request wins arbitration, it gets a small tag. Every agent then writes the request into the slot named by that tag. The slot holds the block address, the command, the agent that issued it, whether this agent has to supply the data, and this cache's snoop state for the block once that state is known. When the data response carrying the same tag appears, the slot is released and the tag can be given out again.

Allocation is indexed by tag, but every slot is also compared in parallel against two addresses: the address of a new bus request and the address of a local processor access. A bus request to a block that already has a live slot is refused with a negative acknowledge in the same cycle, so at most one transaction per block is ever in flight. A processor read that meets a pending read to the same block is told to merge with it. Any other processor access that meets a live slot is told to hold off. An inspection port reads one slot by tag, so the table contents can be observed.

Top module: `txn_track_table`

## Requirements
- R1: After reset every slot is empty: `busy_mask` is zero and the inspection port reports `rd_valid` low for every tag.
- R2: A bus request that is not refused is written into the slot whose index equals `breq_tag`. From the next cycle that slot shows valid, the request's address, command, originator and my-response flag, with `rd_known` low.
- R3: In the cycle a bus request arrives, `breq_nack` is high exactly when its address equals the address of a valid slot. A refused request changes no slot.
- R4: A response with tag T empties slot T from the next cycle on. If an accepted bus request names the same tag in that same cycle, the new request occupies the slot and no error is raised.
- R5: A snoop update for tag T records the state and sets `rd_known` from the next cycle on, provided slot T is valid and is neither freed nor reallocated in that cycle. A snoop update to an empty slot changes nothing.
- R6: With `pq_valid` high, `pq_hit` is high in the same cycle exactly when `pq_addr` equals the address of a valid slot, and `pq_hit_tag` gives that slot's index.
- R7: Command codes are 0 read, 1 read-exclusive, 2 upgrade, 3 writeback. A processor read (`pq_read` high) that hits a slot holding command 0 raises `pq_merge`. Every other hit raises `pq_block`. The two are never high together.
- R8: `alloc_err` is high in the same cycle when an accepted bus request names a slot that is already valid and is not freed in that cycle. The slot is then overwritten with the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| breq_valid | input | 1 | A bus request is on the address bus this cycle |
| breq_tag | input | TAG_W | Tag assigned to the request at arbitration |
| breq_addr | input | ADDR_W | Block address of the request |
| breq_cmd | input | 2 | Command code (0 read, 1 read-exclusive, 2 upgrade, 3 writeback) |
| breq_orig | input | ORIG_W | Issuing agent ID |
| breq_mine | input | 1 | This agent must supply the data |
| breq_nack | output | 1 | Request conflicts with a live slot and is refused |
| alloc_err | output | 1 | Accepted request landed on an occupied slot |
| snp_valid | input | 1 | Snoop state for a tag is available |
| snp_tag | input | TAG_W | Tag whose snoop state is reported |
| snp_state | input | STATE_W | This cache's state for the block |
| rsp_valid | input | 1 | A tagged response is on the data bus |
| rsp_tag | input | TAG_W | Tag carried by the response |
| pq_valid | input | 1 | Processor access present |
| pq_addr | input | ADDR_W | Processor block address |
| pq_read | input | 1 | Processor access is a read |
| pq_hit | output | 1 | Processor address matches a live slot |
| pq_hit_tag | output | TAG_W | Index of the matching slot |
| pq_merge | output | 1 | Read may join the pending read |
| pq_block | output | 1 | Access must wait for the pending transaction |
| rd_tag | input | TAG_W | Slot selected for inspection |
| rd_valid | output | 1 | Selected slot is live |
| rd_addr | output | ADDR_W | Selected slot address |
| rd_cmd | output | 2 | Selected slot command |
| rd_orig | output | ORIG_W | Selected slot originator |
| rd_mine | output | 1 | Selected slot my-response flag |
| rd_state | output | STATE_W | Selected slot snoop state |
| rd_known | output | 1 | Snoop state has been recorded |
| busy_mask | output | 2**TAG_W | Valid bit of every slot |

## Verification
Same-cycle collisions on one tag are the hardest cases to reach from the ports: a response freeing a slot while a new request claims it, and a snoop update racing a free. Both need the bench to line up three independent input groups in one cycle. The bench drives every event through a single step task that can assert any mix of request, snoop and response at once. It checks each combination against a slot-level model. It fills all eight slots with distinct addresses and sweeps refusal, lookup and merge decisions over every slot and both access kinds.

// File: rtl/txn_track_table.sv
module txn_track_table #(
  parameter int TAG_W   = 3,
  parameter int ADDR_W  = 16,
  parameter int ORIG_W  = 4,
  parameter int STATE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   breq_valid,
  input  logic [TAG_W-1:0]       breq_tag,
  input  logic [ADDR_W-1:0]      breq_addr,
  input  logic [1:0]             breq_cmd,
  input  logic [ORIG_W-1:0]      breq_orig,
  input  logic                   breq_mine,
  output logic                   breq_nack,
  output logic                   alloc_err,
  input  logic                   snp_valid,
  input  logic [TAG_W-1:0]       snp_tag,
  input  logic [STATE_W-1:0]     snp_state,
  input  logic                   rsp_valid,
  input  logic [TAG_W-1:0]       rsp_tag,
  input  logic                   pq_valid,
  input  logic [ADDR_W-1:0]      pq_addr,
  input  logic                   pq_read,
  output logic                   pq_hit,
  output logic [TAG_W-1:0]       pq_hit_tag,
  output logic                   pq_merge,
  output logic                   pq_block,
  input  logic [TAG_W-1:0]       rd_tag,
  output logic                   rd_valid,
  output logic [ADDR_W-1:0]      rd_addr,
  output logic [1:0]             rd_cmd,
  output logic [ORIG_W-1:0]      rd_orig,
  output logic                   rd_mine,
  output logic [STATE_W-1:0]     rd_state,
  output logic                   rd_known,
  output logic [(1<<TAG_W)-1:0]  busy_mask
);
  localparam int ENTRIES = 1 << TAG_W;
  localparam logic [1:0] CMD_READ = 2'd0;

  logic [ENTRIES-1:0] vld, known, mine;
  logic [ADDR_W-1:0]  addr  [ENTRIES];
  logic [1:0]         cmd   [ENTRIES];
  logic [ORIG_W-1:0]  orig  [ENTRIES];
  logic [STATE_W-1:0] state [ENTRIES];

  logic [ENTRIES-1:0] bus_match, pq_match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign bus_match[g] = vld[g] && (addr[g] == breq_addr);
      assign pq_match[g]  = vld[g] && (addr[g] == pq_addr);
    end
  endgenerate

  logic             accept, free_same;
  logic [TAG_W-1:0] hit_idx;

  assign breq_nack = breq_valid && |bus_match;
  assign accept    = breq_valid && !breq_nack;
  assign free_same = rsp_valid && (rsp_tag == breq_tag);
  assign alloc_err = accept && vld[breq_tag] && !free_same;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (pq_match[i]) hit_idx = hit_idx | TAG_W'(i);
  end

  assign pq_hit     = pq_valid && |pq_match;
  assign pq_hit_tag = hit_idx;
  assign pq_merge   = pq_hit && pq_read && (cmd[hit_idx] == CMD_READ);
  assign pq_block   = pq_hit && !pq_merge;

  assign rd_valid  = vld[rd_tag];
  assign rd_addr   = addr[rd_tag];
  assign rd_cmd    = cmd[rd_tag];
  assign rd_orig   = orig[rd_tag];
  assign rd_mine   = mine[rd_tag];
  assign rd_state  = state[rd_tag];
  assign rd_known  = known[rd_tag];
  assign busy_mask = vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      known <= '0;
      mine  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        addr[i]  <= '0;
        cmd[i]   <= '0;
        orig[i]  <= '0;
        state[i] <= '0;
      end
    end else begin
      if (snp_valid && vld[snp_tag]) begin
        state[snp_tag] <= snp_state;
        known[snp_tag] <= 1'b1;
      end
      if (rsp_valid) begin
        vld[rsp_tag]   <= 1'b0;
        known[rsp_tag] <= 1'b0;
      end
      if (accept) begin
        vld[breq_tag]   <= 1'b1;
        known[breq_tag] <= 1'b0;
        addr[breq_tag]  <= breq_addr;
        cmd[breq_tag]   <= breq_cmd;
        orig[breq_tag]  <= breq_orig;
        mine[breq_tag]  <= breq_mine;
      end
    end
  end
endmodule

// File: rtl/txn_track_table_chk.sv
module txn_track_table_chk #(
  parameter int TAG_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  breq_valid,
  input logic [TAG_W-1:0]      breq_tag,
  input logic                  breq_nack,
  input logic                  alloc_err,
  input logic                  rsp_valid,
  input logic [TAG_W-1:0]      rsp_tag,
  input logic                  pq_valid,
  input logic                  pq_read,
  input logic                  pq_hit,
  input logic                  pq_merge,
  input logic                  pq_block,
  input logic [(1<<TAG_W)-1:0] busy_mask
);
  p_alloc_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    breq_valid && !breq_nack |=> busy_mask[$past(breq_tag)]);

  p_nack_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    breq_valid && breq_nack && !rsp_valid |=> $stable(busy_mask));

  p_nack_needs_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    breq_nack |-> busy_mask != '0);

  p_free_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !(breq_valid && !breq_nack && breq_tag == rsp_tag)
    |=> !busy_mask[$past(rsp_tag)]);

  p_hit_needs_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pq_hit |-> pq_valid && busy_mask != '0);

  p_merge_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pq_merge |-> pq_read && pq_hit);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pq_merge, pq_block}));

  p_err_occupied_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |-> busy_mask[breq_tag] && breq_valid && !breq_nack);
endmodule

bind txn_track_table txn_track_table_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .breq_valid(breq_valid), .breq_tag(breq_tag),
  .breq_nack(breq_nack), .alloc_err(alloc_err), .rsp_valid(rsp_valid),
  .rsp_tag(rsp_tag), .pq_valid(pq_valid), .pq_read(pq_read), .pq_hit(pq_hit),
  .pq_merge(pq_merge), .pq_block(pq_block), .busy_mask(busy_mask)
);

// File: tb/sim_txn_track_table.sv
`timescale 1ns/1ps
module sim_txn_track_table;
  localparam int TW = 3, AW = 16, OW = 4, SW = 2, N = 8;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic breq_valid = 0, breq_mine = 0, snp_valid = 0, rsp_valid = 0;
  logic pq_valid = 0, pq_read = 0;
  logic [TW-1:0] breq_tag = 0, snp_tag = 0, rsp_tag = 0, rd_tag = 0;
  logic [AW-1:0] breq_addr = 0, pq_addr = 0;
  logic [1:0] breq_cmd = 0;
  logic [OW-1:0] breq_orig = 0;
  logic [SW-1:0] snp_state = 0;
  logic breq_nack, alloc_err, pq_hit, pq_merge, pq_block;
  logic rd_valid, rd_mine, rd_known;
  logic [TW-1:0] pq_hit_tag;
  logic [AW-1:0] rd_addr;
  logic [1:0] rd_cmd;
  logic [OW-1:0] rd_orig;
  logic [SW-1:0] rd_state;
  logic [N-1:0] busy_mask;

  txn_track_table #(.TAG_W(TW), .ADDR_W(AW), .ORIG_W(OW), .STATE_W(SW)) u0 (.*);

  int vecs = 0, bad = 0;
  logic          m_v [N];
  logic [AW-1:0] m_a [N];
  logic [1:0]    m_c [N];
  logic [OW-1:0] m_o [N];
  logic          m_m [N];
  logic [SW-1:0] m_s [N];
  logic          m_k [N];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] m_mask();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = m_v[i];
    return r;
  endfunction

  task automatic step(input logic bv, input int bt, input int ba, input int bc,
                      input int bo, input logic bm, input logic sv, input int st,
                      input int ss, input logic rv, input int rt, input string req);
    logic en, ee, live_s;
    @(negedge clk);
    breq_valid = bv; breq_tag = TW'(bt); breq_addr = AW'(ba); breq_cmd = 2'(bc);
    breq_orig = OW'(bo); breq_mine = bm; snp_valid = sv; snp_tag = TW'(st);
    snp_state = SW'(ss); rsp_valid = rv; rsp_tag = TW'(rt);
    #1;
    en = 0;
    for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == AW'(ba)) en = 1;
    en = en && bv;
    ee = bv && !en && m_v[bt] && !(rv && rt == bt);
    chk({req, " nack R3"}, breq_nack, en);
    chk({req, " err R8"}, alloc_err, ee);
    live_s = m_v[st];
    @(posedge clk);
    if (sv && live_s) begin m_s[st] = SW'(ss); m_k[st] = 1; end
    if (rv) begin m_v[rt] = 0; m_k[rt] = 0; end
    if (bv && !en) begin
      m_v[bt] = 1; m_k[bt] = 0; m_a[bt] = AW'(ba); m_c[bt] = 2'(bc);
      m_o[bt] = OW'(bo); m_m[bt] = bm;
    end
    @(negedge clk);
    breq_valid = 0; snp_valid = 0; rsp_valid = 0;
  endtask

  task automatic check_all(string req);
    for (int t = 0; t < N; t++) begin
      rd_tag = TW'(t); #0.5;
      chk({req, " valid"}, rd_valid, m_v[t]);
      if (m_v[t]) begin
        chk({req, " addr"}, rd_addr, m_a[t]);
        chk({req, " cmd"}, rd_cmd, m_c[t]);
        chk({req, " orig"}, rd_orig, m_o[t]);
        chk({req, " mine"}, rd_mine, m_m[t]);
        chk({req, " known"}, rd_known, m_k[t]);
        if (m_k[t]) chk({req, " state"}, rd_state, m_s[t]);
      end
    end
    chk({req, " mask"}, busy_mask, m_mask());
  endtask

  task automatic probe(int a, logic rdk);
    logic h, mg;
    int ht;
    h = 0; ht = 0; mg = 0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_a[i] == AW'(a)) begin h = 1; ht = i; mg = rdk && m_c[i] == 2'd0; end
    pq_valid = 1; pq_addr = AW'(a); pq_read = rdk; #0.5;
    chk("hit R6", pq_hit, h);
    if (h) chk("hit_tag R6", pq_hit_tag, ht);
    chk("merge R7", pq_merge, mg);
    chk("block R7", pq_block, h && !mg);
    pq_valid = 0; #0.5;
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_a[i] = 0; m_c[i] = 0; m_o[i] = 0; m_m[i] = 0; m_s[i] = 0; m_k[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check_all("reset R1");

    for (int t = 0; t < N; t++)
      step(1, t, 16'h100 + t * 3, t % 4, t + 5, t[0], 0, 0, 0, 0, 0, "fill R2");
    check_all("fill R2");

    for (int t = 0; t < N; t++)
      step(1, (t + 3) % N, 16'h100 + t * 3, 1, 2, 0, 0, 0, 0, 0, 0, "dup R3");
    check_all("after nack R3");

    for (int t = 0; t < N; t++)
      step(0, 0, 0, 0, 0, 0, 1, t, (t * 3) % 4, 0, 0, "snoop R5");
    check_all("snoop R5");

    for (int t = 0; t < N; t++) begin
      probe(16'h100 + t * 3, 1);
      probe(16'h100 + t * 3, 0);
    end
    probe(16'h0FFF, 1);
    probe(16'h0FFF, 0);

    for (int t = 0; t < N; t += 2)
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, t, "free R4");
    check_all("free R4");
    probe(16'h100, 1);

    step(0, 0, 0, 0, 0, 0, 1, 2, 3, 0, 0, "snoop empty R5");
    check_all("snoop empty R5");
    step(0, 0, 0, 0, 0, 0, 1, 5, 1, 1, 5, "snoop vs free R5");
    check_all("snoop vs free R5");

    step(1, 1, 16'h2222, 0, 9, 1, 0, 0, 0, 0, 0, "overwrite R8");
    check_all("overwrite R8");
    step(1, 3, 16'h3333, 2, 7, 0, 1, 3, 2, 1, 3, "free+alloc R4");
    check_all("free+alloc R4");
    step(1, 4, 16'h2222, 0, 1, 0, 0, 0, 0, 1, 1, "nack vs free R3");
    check_all("nack vs free R3");

    for (int t = 0; t < N; t++)
      step(1, t, 16'h4000 + t, (t + 1) % 4, t, !t[0], 0, 0, 0, 0, 0, "refill R2");
    check_all("refill R2");
    for (int t = 0; t < N; t++) probe(16'h4000 + t, 1);
    for (int t = 0; t < N; t++)
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, t, "drain R4");
    check_all("drain R4");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule